// File: doc/BRIEF.md
# Two-Stream Backplane Time-Slot Interchange

This block switches channels from backplane inputs to backplane outputs. Many backplane input streams arrive in parallel, one channel beat per transfer, but only two of them can feed the switch. Two selection inputs name those streams, called A and B. Every frame, the block stores each input channel of A and B in a banked data memory. A connection memory holds one entry per output slot, and that entry picks a stored channel and a stream. The block then emits the output frame slot by slot, two frames after the matching input frame.

The rate-mode input sets the frame size. The low rate has `LO_CH` channels (512 by default) and the high rate has `HI_CH` channels (1,024 by default). The selection inputs and the rate mode are sampled only on the frame pulse. Connection-memory writes take effect immediately for every later read.

Both data interfaces use valid/ready. The input side refuses beats before the first frame pulse, on the frame-pulse cycle, and after the frame's capacity is reached. Refused beats are not stored. The output side holds its slot index and data while `out_ready` is low. No slot is lost to back-pressure. The downstream side must accept all slots of a frame before the next frame pulse, because the pulse restarts the output count.

Top module: `bp_tsi_top`

## Requirements
- R1: After reset, `in_ready` and `out_valid` are low, and `in_ready` stays low until the first frame pulse.
- R2: The stored A and B channels come from input stream `sel_a` and stream `sel_b`. Stream s occupies bits [8s+7:8s] of `in_data`, and both selections must be below `NSTR`.
- R3: A change of `sel_a` or `sel_b` in the middle of a frame does not affect that frame. It applies from the next frame pulse.
- R4: Channels accepted in the frame opened by frame pulse n are output in the frame opened by pulse n+2. `out_valid` stays low in the frames opened by the first two pulses.
- R5: Each frame, exactly `HI_CH` (high rate) or `LO_CH` (low rate) input beats are accepted, and then `in_ready` drops. Exactly that many output slots are offered, numbered 0 upward on `out_chan`.
- R6: Output slot j carries the stored channel `cm_chan` of the entry last written to address j. It comes from stream A when `cm_src` is 0 and from stream B when `cm_src` is 1.
- R7: In the low-rate mode, a slot whose connection entry names a channel at or above `LO_CH` outputs 8'hFF.
- R8: While `out_valid` is high and `out_ready` is low, `out_chan` and `out_data` hold until the handshake or the next frame pulse, provided the connection memory is not written.
- R9: `hi_rate` is sampled only on the frame pulse. A change in the middle of a frame leaves that frame's slot count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fp | input | 1 | One-cycle frame pulse that opens a frame |
| hi_rate | input | 1 | Rate mode: 1 selects `HI_CH` channels, 0 selects `LO_CH` channels |
| sel_a | input | SELW | Stream index used as source A |
| sel_b | input | SELW | Stream index used as source B |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high together with `in_valid` |
| in_data | input | NSTR*8 | One channel byte from every backplane input stream |
| cm_we | input | 1 | Connection-memory write strobe |
| cm_addr | input | CHW | Output slot written |
| cm_src | input | 1 | Source stream of the entry: 0 for A, 1 for B |
| cm_chan | input | CHW | Stored channel index of the entry |
| out_valid | output | 1 | Output slot valid |
| out_ready | input | 1 | Downstream accepts the slot |
| out_data | output | 8 | Switched channel byte |
| out_chan | output | CHW | Output slot index |

## Verification
A bank pointer that is off by one shows up on the first switched frame. Those slots carry data one or three frames old, so `out_data` is wrong on every slot of that frame. A selection or rate register that updates outside the frame pulse changes the source stream or the slot count within the same frame. This shows as a wrong byte or a count mismatch at the end of that frame. A wrong slot counter shows up at once, as a wrong `out_chan` or a changed slot on the first stalled cycle.

// File: rtl/bp_tsi_pkg.sv
`timescale 1ns/1ps
package bp_tsi_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
endpackage

// File: rtl/bp_tsi_framectl.sv
`timescale 1ns/1ps
module bp_tsi_framectl #(
  parameter int unsigned LO_CH = 512,
  parameter int unsigned HI_CH = 1024,
  parameter int unsigned SELW  = 5,
  parameter int unsigned BANKS = 3,
  parameter int unsigned CHW   = $clog2(HI_CH),
  parameter int unsigned BW    = $clog2(BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fp,
  input  logic            hi_rate,
  input  logic [SELW-1:0] sel_a,
  input  logic [SELW-1:0] sel_b,
  input  logic            in_fire,
  input  logic            out_fire,
  output logic            hi_q,
  output logic [SELW-1:0] sel_a_q,
  output logic [SELW-1:0] sel_b_q,
  output logic [BW-1:0]   wbank,
  output logic [BW-1:0]   rbank,
  output logic [CHW-1:0]  in_idx,
  output logic [CHW-1:0]  out_idx,
  output logic            in_open,
  output logic            out_open
);
  localparam int unsigned CNTW = CHW + 1;
  localparam int unsigned FPW  = $clog2(BANKS + 1);

  logic [CNTW-1:0] in_cnt, out_cnt, nch;
  logic [FPW-1:0]  fp_seen;

  assign nch     = hi_q ? CNTW'(HI_CH) : CNTW'(LO_CH);
  assign rbank   = (wbank == BW'(BANKS - 1)) ? '0 : wbank + 1'b1;
  assign in_idx  = in_cnt[CHW-1:0];
  assign out_idx = out_cnt[CHW-1:0];
  assign in_open  = (fp_seen != '0) && (in_cnt < nch) && !fp;
  assign out_open = (fp_seen == FPW'(BANKS)) && (out_cnt < nch) && !fp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbank   <= '0;
      hi_q    <= 1'b0;
      sel_a_q <= '0;
      sel_b_q <= '0;
      in_cnt  <= '0;
      out_cnt <= '0;
      fp_seen <= '0;
    end else if (fp) begin
      wbank   <= rbank;
      hi_q    <= hi_rate;
      sel_a_q <= sel_a;
      sel_b_q <= sel_b;
      in_cnt  <= '0;
      out_cnt <= '0;
      if (fp_seen != FPW'(BANKS)) fp_seen <= fp_seen + 1'b1;
    end else begin
      if (in_fire)  in_cnt  <= in_cnt + 1'b1;
      if (out_fire) out_cnt <= out_cnt + 1'b1;
    end
  end

  // R3
  sel_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fp |=> ($stable(sel_a_q) && $stable(sel_b_q) && $stable(hi_q)));

  // R4
  bank_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp |=> (wbank != $past(wbank)));

  // R5
  in_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cnt <= nch) && (out_cnt <= nch));
endmodule

// File: rtl/bp_tsi_datamem.sv
`timescale 1ns/1ps
module bp_tsi_datamem #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned BANKS = 3,
  parameter int unsigned CHW   = $clog2(DEPTH),
  parameter int unsigned BW    = $clog2(BANKS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [BW-1:0]  wbank,
  input  logic [CHW-1:0] wchan,
  input  logic [DW-1:0]  wdata_a,
  input  logic [DW-1:0]  wdata_b,
  input  logic [BW-1:0]  rbank,
  input  logic           rsrc,
  input  logic [CHW-1:0] rchan,
  output logic [DW-1:0]  rdata
);
  localparam int unsigned WORDS = BANKS * DEPTH;
  localparam int unsigned AW    = $clog2(WORDS);

  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] wd [2];
  logic [DW-1:0] rd [2];

  assign waddr = AW'(wbank) * AW'(DEPTH) + AW'(wchan);
  assign raddr = AW'(rbank) * AW'(DEPTH) + AW'(rchan);
  assign wd[0] = wdata_a;
  assign wd[1] = wdata_b;

  for (genvar s = 0; s < 2; s++) begin : g_stream
    logic [DW-1:0] mem [WORDS];
    always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wd[s];
    end
    assign rd[s] = mem[raddr];
  end

  assign rdata = rsrc ? rd[1] : rd[0];

  // R4
  bank_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wbank != rbank));
endmodule

// File: rtl/bp_tsi_connmem.sv
`timescale 1ns/1ps
module bp_tsi_connmem #(
  parameter int unsigned DEPTH = 1024,
  parameter int unsigned CHW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [CHW-1:0] waddr,
  input  logic           wsrc,
  input  logic [CHW-1:0] wchan,
  input  logic [CHW-1:0] raddr,
  output logic           rsrc,
  output logic [CHW-1:0] rchan
);
  logic [CHW:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {wsrc, wchan};
  end

  assign {rsrc, rchan} = mem[raddr];
endmodule

// File: rtl/bp_tsi_top.sv
`timescale 1ns/1ps
module bp_tsi_top
  import bp_tsi_pkg::*;
#(
  parameter int unsigned NSTR  = 32,
  parameter int unsigned LO_CH = 512,
  parameter int unsigned HI_CH = 1024,
  parameter int unsigned DELAY = 2,
  parameter int unsigned SELW  = $clog2(NSTR),
  parameter int unsigned CHW   = $clog2(HI_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fp,
  input  logic                   hi_rate,
  input  logic [SELW-1:0]        sel_a,
  input  logic [SELW-1:0]        sel_b,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [NSTR*BYTE_W-1:0] in_data,
  input  logic                   cm_we,
  input  logic [CHW-1:0]         cm_addr,
  input  logic                   cm_src,
  input  logic [CHW-1:0]         cm_chan,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [BYTE_W-1:0]      out_data,
  output logic [CHW-1:0]         out_chan
);
  localparam int unsigned BANKS = DELAY + 1;
  localparam int unsigned BW    = $clog2(BANKS);

  logic            hi_q, in_fire, out_fire;
  logic [SELW-1:0] sel_a_q, sel_b_q;
  logic [BW-1:0]   wbank, rbank;
  logic [CHW-1:0]  in_idx, out_idx, map_chan;
  logic            map_src;
  logic [BYTE_W-1:0] mem_byte, byte_a, byte_b;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid && out_ready;
  assign byte_a   = in_data[sel_a_q*BYTE_W +: BYTE_W];
  assign byte_b   = in_data[sel_b_q*BYTE_W +: BYTE_W];

  bp_tsi_framectl #(.LO_CH(LO_CH), .HI_CH(HI_CH), .SELW(SELW), .BANKS(BANKS),
                    .CHW(CHW), .BW(BW)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fp(fp), .hi_rate(hi_rate),
    .sel_a(sel_a), .sel_b(sel_b), .in_fire(in_fire), .out_fire(out_fire),
    .hi_q(hi_q), .sel_a_q(sel_a_q), .sel_b_q(sel_b_q),
    .wbank(wbank), .rbank(rbank), .in_idx(in_idx), .out_idx(out_idx),
    .in_open(in_ready), .out_open(out_valid)
  );

  bp_tsi_connmem #(.DEPTH(HI_CH), .CHW(CHW)) u_cm (
    .clk(clk), .we(cm_we), .waddr(cm_addr), .wsrc(cm_src), .wchan(cm_chan),
    .raddr(out_idx), .rsrc(map_src), .rchan(map_chan)
  );

  bp_tsi_datamem #(.DW(BYTE_W), .DEPTH(HI_CH), .BANKS(BANKS), .CHW(CHW), .BW(BW)) u_dm (
    .clk(clk), .rst_n(rst_n), .we(in_fire), .wbank(wbank), .wchan(in_idx),
    .wdata_a(byte_a), .wdata_b(byte_b), .rbank(rbank),
    .rsrc(map_src == SRC_B), .rchan(map_chan), .rdata(mem_byte)
  );

  assign out_chan = out_idx;
  assign out_data = (!hi_q && (map_chan >= CHW'(LO_CH))) ? IDLE_BYTE : mem_byte;

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !cm_we) |=>
      (fp || (out_chan == $past(out_chan) && out_data == $past(out_data))));

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> $past(fp));
endmodule

// File: tb/test_bp_tsi_top.sv
`timescale 1ns/1ps
module test_bp_tsi_top;
  localparam int NS = 4, LO = 8, HI = 16, CW = 4, NF = 10;

  logic clk = 0, rst_n = 0, fp = 0, hi_rate = 1;
  logic [1:0] sel_a = 2'd1, sel_b = 2'd2;
  logic in_valid = 0, in_ready;
  logic [NS*8-1:0] in_data = '0;
  logic cm_we = 0, cm_src = 0;
  logic [CW-1:0] cm_addr = '0, cm_chan = '0;
  logic out_valid, out_ready = 0;
  logic [7:0] out_data;
  logic [CW-1:0] out_chan;

  int checks = 0, errors = 0, cyc = 0, out_seen = 0;
  int q_chan[$], q_data[$];
  bit q_dc[$];
  bit modeh[0:NF];
  int sa[0:NF], sb[0:NF];
  int cm_s[0:HI-1], cm_c[0:HI-1];

  always #10 clk = ~clk;

  bp_tsi_top #(.NSTR(NS), .LO_CH(LO), .HI_CH(HI)) i_bp_tsi_top (
    .clk(clk), .rst_n(rst_n), .fp(fp), .hi_rate(hi_rate), .sel_a(sel_a), .sel_b(sel_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .cm_we(cm_we), .cm_addr(cm_addr), .cm_src(cm_src), .cm_chan(cm_chan),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_chan(out_chan));

  function automatic logic [7:0] val(int f, int s, int c);
    return 8'(f * 37 + s * 11 + c * 3 + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 out_ready <= (cyc % 5) != 2;
  end

  bit prev_stall = 0;
  int prev_chan = 0, prev_data = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall && out_valid && !fp) begin
        check(out_chan == CW'(prev_chan) && out_data == 8'(prev_data), "R8 hold",
              int'(out_chan), prev_chan);
      end
      prev_stall = out_valid && !out_ready && !cm_we;
      prev_chan = out_chan;
      prev_data = out_data;
      if (out_valid && out_ready) begin
        out_seen++;
        if (q_chan.size() == 0) begin
          check(0, "R4 unexpected slot", int'(out_chan), -1);
        end else begin
          int ec, ed;
          bit dc;
          ec = q_chan.pop_front(); ed = q_data.pop_front(); dc = q_dc.pop_front();
          check(out_chan == CW'(ec), "R5 slot index", int'(out_chan), ec);
          if (!dc) check(out_data == 8'(ed), "R6/R7 data", int'(out_data), ed);
        end
      end
    end
  end

  task automatic write_cm(int mode);
    for (int j = 0; j < HI; j++) begin
      @(posedge clk); #1;
      cm_we = 1; cm_addr = CW'(j);
      cm_s[j] = (mode == 0) ? (j % 2) : 1 - (j % 2);
      cm_c[j] = (mode == 0) ? (HI - 1 - j) : ((j * 2) % HI);
      cm_src = cm_s[j][0]; cm_chan = CW'(cm_c[j]);
    end
    @(posedge clk); #1 cm_we = 0;
  endtask

  task automatic push_frame(int f);
    int n, fs;
    n = modeh[f] ? HI : LO;
    fs = f - 2;
    for (int j = 0; j < n; j++) begin
      int c, st;
      c = cm_c[j];
      st = (cm_s[j] == 1) ? sb[fs] : sa[fs];
      q_chan.push_back(j);
      if (!modeh[f] && c >= LO) begin
        q_data.push_back(8'hFF); q_dc.push_back(0);
      end else if (!modeh[fs] && c >= LO) begin
        q_data.push_back(0); q_dc.push_back(1);
      end else begin
        q_data.push_back(int'(val(fs, st, c))); q_dc.push_back(0);
      end
    end
  endtask

  task automatic run_frame(int f, bit chg_sel, bit chg_mode);
    int n;
    @(posedge clk); #1;
    fp = 1;
    modeh[f] = hi_rate; sa[f] = int'(sel_a); sb[f] = int'(sel_b);
    out_seen = 0;
    if (f >= 3) push_frame(f);
    @(posedge clk); #1 fp = 0;
    n = modeh[f] ? HI : LO;
    for (int ch = 0; ch < n; ch++) begin
      in_valid = 1;
      for (int s = 0; s < NS; s++) in_data[s*8 +: 8] = val(f, s, ch);
      if (chg_sel && ch == 3) sel_a = 2'd3;
      if (chg_mode && ch == 3) hi_rate = 1;
      @(negedge clk);
      check(in_ready == 1, "R5 ready within frame", int'(in_ready), 1);
      @(posedge clk); #1;
    end
    for (int s = 0; s < NS; s++) in_data[s*8 +: 8] = 8'h5A;
    @(negedge clk);
    check(in_ready == 0, "R5 ready drops at capacity", int'(in_ready), 0);
    @(posedge clk); #1 in_valid = 0;
    while (q_chan.size() > 0) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
    check(out_seen == ((f >= 3) ? n : 0), "R4/R5/R9 slot count", out_seen, (f >= 3) ? n : 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 0 && out_valid == 0, "R1 reset state", int'({in_ready, out_valid}), 0);
    #1 rst_n = 1;
    @(negedge clk);
    check(in_ready == 0, "R1 no input before frame pulse", int'(in_ready), 0);
    write_cm(0);                          // R6 reversed map, alternating A/B
    run_frame(1, 0, 0);                   // R2 streams 1 and 2
    run_frame(2, 0, 0);
    run_frame(3, 1, 0);                   // R3 sel_a moved mid-frame
    run_frame(4, 0, 0);
    hi_rate = 0;                          // R9 low rate from frame 5
    run_frame(5, 0, 0);
    write_cm(1);                          // R7 entries at or above LO
    run_frame(6, 0, 0);
    run_frame(7, 0, 1);                   // R9 mid-frame rate change
    run_frame(8, 0, 0);
    run_frame(9, 0, 0);
    run_frame(10, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule